// File: doc/BRIEF.md
# Paused Counter Hex Streamer

This block keeps a 32-bit counter that advances once per tick period, 100 ms by default. Each time the counter takes a new value, the block writes that value out as one line of ASCII text: eight uppercase hexadecimal digits followed by a carriage return and a line feed. The bytes go out on a valid/ready byte stream that a UART transmitter (8N1, 115200 baud) would consume.

An active-low push button is passed through a two-stage synchronizer. Each press switches the counter between running and paused. A synchronous clear input, driven for example by a sync-word detector, sets the counter to zero, restarts the tick period and causes a line of zeros to be sent.

The stream has the usual back-pressure rules. A byte moves only in a cycle where `m_tvalid` and `m_tready` are both high. While the sink holds `m_tready` low, the byte on offer does not change. A stalled sink never stops the counter. Updates that arrive during a stall are merged, and the next line carries the newest value. The clock frequency is a parameter, so a simulation can use a short tick.

Top module: `hex_line_streamer`

## Requirements
- R1: After reset `m_tvalid` is low, the counter is zero and the block is running (not paused).
- R2: While running, the counter increases by exactly one at the end of every period of TICK_MS × CLK_HZ / 1000 clock cycles.
- R3: Every counter update produces one 10-byte line. The first 8 bytes are the value in hexadecimal, most significant nibble first, using ASCII '0'–'9' (0x30–0x39) and uppercase 'A'–'F' (0x41–0x46). Byte 9 is 0x0D and byte 10 is 0x0A.
- R4: A byte is transferred only in a cycle where `m_tvalid` and `m_tready` are both high. While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high and `m_tdata` keeps its value.
- R5: A falling edge on the synchronized `pause_n` toggles between running and paused. A button held low toggles only once. While paused, the counter and the tick period do not advance and no line is sent.
- R6: `clear` sets the counter and the tick phase to zero and causes a line "00000000" to be sent. The next increment comes one full period after the clear. `clear` takes priority over a tick in the same cycle.
- R7: An update that arrives while a line is being sent does not restart that line. When the line ends, one further line is sent holding the newest counter value, and values in between are not sent.
- R8: After reset with the sink ready, the first byte of the line for value 1 is offered about one tick period after reset is released, within a few cycles of pipeline delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pause_n | input | 1 | Push button, active low, asynchronous to `clk` |
| clear | input | 1 | Synchronous one-cycle request to zero the counter |
| m_tdata | output | 8 | ASCII byte on offer |
| m_tvalid | output | 1 | Byte on offer is valid |
| m_tready | input | 1 | Sink accepts the byte this cycle |

## Verification
The bench holds the sink off across a clear and two later ticks. It then expects the zero line to finish unchanged, followed only by the line for value 2. A design that restarts lines would send a broken or repeated line, and one that queues every value would also send value 1. The bench holds the button low for longer than two tick periods to catch a level-sensitive toggle, which would pause again at once. It also times the first increment after a clear, which shows whether the tick phase is really reset. Values 0x0A–0x0C check that the hex digits are uppercase, and an irregular ready pattern checks that stalled bytes stay stable.

// File: rtl/hls_pkg.sv
package hls_pkg;
  localparam logic [7:0] ASCII_CR = 8'h0D;
  localparam logic [7:0] ASCII_LF = 8'h0A;

  function automatic logic [7:0] hex_char(input logic [3:0] nib);
    return (nib < 4'd10) ? (8'h30 + {4'h0, nib}) : (8'h37 + {4'h0, nib});
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PERIOD = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (run)     phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  assign tick = run && !restart && (phase == LAST);

  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(phase)); // R5
endmodule

// File: rtl/pause_toggle.sv
module pause_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic paused
);
  logic meta, sync, last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= 1'b1;
      sync <= 1'b1;
      last <= 1'b1;
      paused <= 1'b0;
    end else begin
      meta <= btn_n;
      sync <= meta;
      last <= sync;
      if (last && !sync) paused <= !paused;
    end
  end

  AST_HELD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !last) |=> $stable(paused)); // R5
endmodule

// File: rtl/line_former.sv
module line_former
  import hls_pkg::*;
#(
  parameter int unsigned VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [VAL_W-1:0] value,
  output logic             take,
  output logic [7:0]       tdata,
  output logic             tvalid,
  input  logic             tready
);
  localparam int unsigned NCHR  = VAL_W / 4;
  localparam int unsigned NBYTE = NCHR + 2;
  localparam int unsigned IW    = $clog2(NBYTE);
  localparam logic [IW-1:0] LAST_IDX = IW'(NBYTE - 1);
  localparam logic [IW-1:0] CR_IDX   = IW'(NCHR);

  logic             busy;
  logic [IW-1:0]    idx;
  logic [VAL_W-1:0] shreg;
  logic             fire;

  assign take = load_req && !busy;
  assign fire = busy && tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      shreg <= '0;
    end else if (take) begin
      busy  <= 1'b1;
      idx   <= '0;
      shreg <= value;
    end else if (fire) begin
      if (idx == LAST_IDX) busy <= 1'b0;
      else                 idx  <= idx + 1'b1;
      if (idx < CR_IDX)    shreg <= shreg << 4;
    end
  end

  always_comb begin
    if (idx < CR_IDX)       tdata = hex_char(shreg[VAL_W-1 -: 4]);
    else if (idx == CR_IDX) tdata = ASCII_CR;
    else                    tdata = ASCII_LF;
  end

  assign tvalid = busy;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> (tvalid && $stable(tdata))); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(tready && idx == LAST_IDX)) |=> (busy && idx >= $past(idx))); // R7
endmodule

// File: rtl/hex_line_streamer.sv
module hex_line_streamer #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TICK_MS = 100,
  parameter int unsigned CNT_W   = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pause_n,
  input  logic       clear,
  output logic [7:0] m_tdata,
  output logic       m_tvalid,
  input  logic       m_tready
);
  localparam int unsigned TICK_CYC = (CLK_HZ / 1000) * TICK_MS;

  logic             paused, tick, take, pending;
  logic [CNT_W-1:0] count;

  pause_toggle u_pause (
    .clk(clk), .rst_n(rst_n), .btn_n(pause_n), .paused(paused)
  );

  tick_prescaler #(.PERIOD(TICK_CYC)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(!paused), .restart(clear), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (tick)  count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              pending <= 1'b0;
    else if (tick || clear)  pending <= 1'b1;
    else if (take)           pending <= 1'b0;
  end

  line_former #(.VAL_W(CNT_W)) u_line (
    .clk(clk), .rst_n(rst_n), .load_req(pending), .value(count), .take(take),
    .tdata(m_tdata), .tvalid(m_tvalid), .tready(m_tready)
  );

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear) |=> (count == $past(count) + 1'b1)); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0 && pending)); // R6
  AST_PAUSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !clear) |=> $stable(count)); // R5
  AST_UPDATE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !take) |=> pending); // R7
endmodule

// File: tb/hex_line_streamer_bench.sv
module hex_line_streamer_bench;
  localparam int unsigned CLK_HZ = 2000;
  localparam int unsigned TICK   = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pause_n = 1'b1;
  logic       clear = 1'b0;
  logic       rdy = 1'b1;
  logic [7:0] m_tdata;
  logic       m_tvalid;

  always #10 clk = ~clk;

  hex_line_streamer #(.CLK_HZ(CLK_HZ), .TICK_MS(100), .CNT_W(32)) u_hex_line_streamer (
    .clk(clk), .rst_n(rst_n), .pause_n(pause_n), .clear(clear),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(rdy)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, lines = 0, hold_err = 0;
  int first_start = -1, last_start = 0, cur_start = 0, nb = 0;
  logic [31:0] exp_q[$];
  logic [79:0] got;
  logic        prev_stall = 1'b0;
  logic [7:0]  prev_data = 8'h00;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [79:0] line_of(input logic [31:0] v);
    logic [79:0] s;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] n;
      n = v[31 - 4*i -: 4];
      s[79 - 8*i -: 8] = (n < 10) ? (8'h30 + {4'h0, n}) : (8'h41 + {4'h0, n} - 8'd10);
    end
    s[15:8] = 8'h0D;
    s[7:0]  = 8'h0A;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && (!m_tvalid || m_tdata != prev_data)) hold_err++;
      prev_stall = m_tvalid && !rdy;
      prev_data  = m_tdata;
      if (m_tvalid && rdy) begin
        if (nb == 0) cur_start = cyc;
        got[79 - 8*nb -: 8] = m_tdata;
        nb++;
        if (nb == 10) begin
          nb = 0;
          lines++;
          last_start = cur_start;
          if (first_start < 0) first_start = cur_start;
          if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected line", got, 80'h0);
          end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check(got == line_of(e), "R3", "line content", got, line_of(e));
          end
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input int limit);
    int t = 0;
    while (exp_q.size() != 0 && t < limit) begin
      step(1);
      t++;
    end
    check(exp_q.size() == 0, "R3", "expected lines arrived", 80'(exp_q.size()), 80'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0, seen, clr_cyc;
    step(5);
    check(m_tvalid == 1'b0, "R1", "tvalid in reset", 80'(m_tvalid), 80'h0);
    @(negedge clk);
    rst_n = 1'b1;
    c0 = cyc;
    step(2);
    check(m_tvalid == 1'b0, "R1", "tvalid after reset", 80'(m_tvalid), 80'h0);

    // R2 / R3 / R8: running sequence including A-F digits
    for (int v = 1; v <= 12; v++) exp_q.push_back(32'(v));
    drain(12 * TICK + 100);
    check(first_start - c0 >= TICK - 2 && first_start - c0 <= TICK + 4, "R8",
          "first line timing", 80'(first_start - c0), 80'(TICK + 1));
    check(lines == 12, "R2", "one line per tick", 80'(lines), 80'd12);

    // R5: pause, stay silent, resume with a long hold
    pause_n = 1'b0; step(5); pause_n = 1'b1;
    seen = lines;
    step(3 * TICK);
    check(lines == seen, "R5", "no lines while paused", 80'(lines), 80'(seen));
    exp_q.push_back(32'd13);
    exp_q.push_back(32'd14);
    pause_n = 1'b0; step(2 * TICK + 60); pause_n = 1'b1;
    drain(2 * TICK);
    check(lines == seen + 2, "R5", "held button toggles once", 80'(lines), 80'(seen + 2));

    // R6: clear restarts value and tick phase
    exp_q.push_back(32'd0);
    exp_q.push_back(32'd1);
    clear = 1'b1; clr_cyc = cyc; step(1); clear = 1'b0;
    drain(TICK + 100);
    check(last_start - clr_cyc >= TICK - 2 && last_start - clr_cyc <= TICK + 6, "R6",
          "full period after clear", 80'(last_start - clr_cyc), 80'(TICK + 2));

    // R7: stalled sink across clear and two ticks
    rdy = 1'b0;
    exp_q.push_back(32'd0);
    exp_q.push_back(32'd2);
    clear = 1'b1; step(1); clear = 1'b0;
    step(2 * TICK + 100);
    check(m_tvalid == 1'b1 && m_tdata == 8'h30, "R4", "stalled byte held",
          80'(m_tdata), 80'h30);
    seen = lines;
    rdy = 1'b1;
    step(40);
    check(lines == seen + 2 && exp_q.size() == 0, "R7", "merged updates", 80'(lines), 80'(seen + 2));
    exp_q.push_back(32'd3);
    drain(TICK + 50);

    // R4: irregular back-pressure
    exp_q.push_back(32'd4);
    exp_q.push_back(32'd5);
    exp_q.push_back(32'd6);
    for (int i = 0; i < 3 * TICK + 60; i++) begin
      rdy = (i % 3 != 0) && (i % 7 != 2);
      step(1);
    end
    rdy = 1'b1;
    drain(TICK);
    check(hold_err == 0, "R4", "stall stability", 80'(hold_err), 80'h0);
    finish_run();
  end
endmodule